// File: doc/BRIEF.md
# Multi-Source Interrupt Hub

The hub gathers three families of interrupt requests and steers them onto a parameterised set of output interrupt lines. Hardware request lines and timer flags come in as level-sensitive input vectors. Software-raised requests live in write-triggered registers that the hub holds itself. Every output line has one mask for each family. Software reaches all of this through a 4 KB window of 32-bit words on a simple valid/ready register port.

Each output line is asserted while any unmasked source of any family is pending. To service an output, a handler reads that output's priority word. The word flags which families have active sources and gives the lowest active index in each family. Arbitration between families is left to software. A software request is acknowledged by reading its register, which returns the stored value and clears it.

A word address splits into a 5-bit function code in bits [11:7], an index in 0..31 in bits [6:2], and bits [1:0], which must be zero. Source and output counts are parameters. A source count may be 0..32, and the output count may be 1..32.

Top module: `irq_hub`

## Requirements
- R1: After reset, all masks and software request registers are zero, every output line is low and no response is valid.
- R2: The port accepts a request in every cycle (`req_ready` is high). Each accepted request produces exactly one response with `rsp_valid` high in the following cycle. A write response carries zero data.
- R3: Function 0 at index i < source count holds software request i. A write stores the 32-bit value, and the request is pending while that value is nonzero. A read returns the stored value and clears it to zero.
- R4: Functions 4, 8 and 12 read or write the whole timer, hardware or software mask of output `idx`. Mask bits at or above that family's source count always read as zero.
- R5: Functions 5, 9 and 13 OR the written ones into the timer, hardware or software mask. Functions 6, 10 and 14 clear the mask bits written as ones.
- R6: A read of function 6, 10 or 14 returns that family's active vector for output `idx`, which is pending AND mask.
- R7: `irq_out[o]` is high exactly when at least one of output o's three active vectors is nonzero.
- R8: Function 15 reads the priority word of output `idx`. Bit 0 flags timer activity, with the lowest active timer index in [12:8]. Bit 1 flags hardware activity, with its index in [20:16]. Bit 2 flags software activity, with its index in [28:24]. All other bits are zero, and an index field is zero when its flag is clear.
- R9: Reads return zero and writes change nothing when any of these holds: address bit 11 is set, bits [1:0] are nonzero, the function is 1, 2, 3, 7 or 11, an output index is at or above the output count, or a software request index is at or above its count. Reads of the set functions 5, 9 and 13 also return zero.
- R10: Hardware lines and timer flags are not latched. Their pending state follows the present input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| hw_irq | input | max(N_HW,1) | Hardware request lines, level-sensitive |
| tmr_irq | input | max(N_TM,1) | Timer request flags, level-sensitive |
| irq_out | output | N_OUT | Output interrupt lines |

## Verification
The checker assumes a single requester that issues at most one request per cycle and holds the address stable during that cycle. Under that assumption, the pairing of requests to responses in the following cycle is well defined. It also assumes that source lines at or above a family's count are never driven high. The bench changes hardware and timer levels only on falling clock edges, between transactions, and drives only the configured widths. Every read therefore observes a settled pending state.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    // family indices used across the hub
    localparam int FAM_TM = 0;
    localparam int FAM_HW = 1;
    localparam int FAM_WT = 2;

    typedef struct packed {
        logic       wti_wr;
        logic       wti_rd;
        logic [2:0] msk_wr;
        logic [2:0] msk_set;
        logic [2:0] msk_clr;
        logic [2:0] msk_rd;
        logic [2:0] act_rd;
        logic       prio_rd;
        logic [4:0] idx;
        logic       out_ok;
        logic       wti_ok;
    } dec_t;

    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } pick_t;

    // bits that exist for a family of n sources
    function automatic logic [31:0] src_valid(int n);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < n) v[i] = 1'b1;
        end
        return v;
    endfunction

    // lowest set index wins
    function automatic pick_t pick_lowest(logic [31:0] v);
        pick_t p;
        p = '0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = 5'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
    import irq_hub_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int N_WT  = 4
) (
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    output dec_t        dec
);

    logic [4:0] fn;
    logic [1:0] fam_sel;
    logic [1:0] sub;
    logic       live;
    int         fam;

    always_comb begin
        fn      = req_addr[11:7];
        fam_sel = fn[3:2];
        sub     = fn[1:0];
        live    = req_valid && (req_addr[1:0] == 2'b00) && !fn[4];
        fam     = (fam_sel == 2'b01) ? FAM_TM :
                  (fam_sel == 2'b10) ? FAM_HW : FAM_WT;

        dec        = '0;
        dec.idx    = req_addr[6:2];
        dec.out_ok = (32'(req_addr[6:2]) < N_OUT);
        dec.wti_ok = (32'(req_addr[6:2]) < N_WT);

        if (live) begin
            if (fn == 5'd0) begin
                dec.wti_wr = req_write && dec.wti_ok;
                dec.wti_rd = !req_write && dec.wti_ok;
            end else if (fam_sel != 2'b00 && dec.out_ok) begin
                unique case (sub)
                    2'b00: begin
                        dec.msk_wr[fam] = req_write;
                        dec.msk_rd[fam] = !req_write;
                    end
                    2'b01: dec.msk_set[fam] = req_write;
                    2'b10: begin
                        dec.msk_clr[fam] = req_write;
                        dec.act_rd[fam]  = !req_write;
                    end
                    default: dec.prio_rd = !req_write && (fam == FAM_WT);
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_hub_wti.sv
module irq_hub_wti
    import irq_hub_pkg::*;
#(
    parameter int N_WT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  dec_t        dec,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [31:0] pend
);

    localparam int WT_W = (N_WT > 0) ? N_WT : 1;

    typedef struct packed {
        logic [WT_W-1:0][31:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < WT_W; i++) begin
            if (i < N_WT && 32'(dec.idx) == i) begin
                rdata = st_q.val[i];
                if (dec.wti_wr) st_d.val[i] = wdata;
                if (dec.wti_rd) st_d.val[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < 32; g++) begin : g_pend
        if (g < N_WT) begin : g_on
            assign pend[g] = |st_q.val[g];
        end else begin : g_off
            assign pend[g] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_hub_masks.sv
module irq_hub_masks
    import irq_hub_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int N_TM  = 4,
    parameter int N_HW  = 4,
    parameter int N_WT  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  dec_t                         dec,
    input  logic [31:0]                  wdata,
    output logic [N_OUT-1:0][2:0][31:0]  msk
);

    localparam logic [2:0][31:0] VALID = {src_valid(N_WT), src_valid(N_HW), src_valid(N_TM)};

    typedef struct packed {
        logic [N_OUT-1:0][2:0][31:0] m;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int o = 0; o < N_OUT; o++) begin
            if (dec.out_ok && 32'(dec.idx) == o) begin
                for (int t = 0; t < 3; t++) begin
                    if (dec.msk_wr[t])  st_d.m[o][t] = wdata & VALID[t];
                    if (dec.msk_set[t]) st_d.m[o][t] = st_q.m[o][t] | (wdata & VALID[t]);
                    if (dec.msk_clr[t]) st_d.m[o][t] = st_q.m[o][t] & ~wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msk = st_q.m;

endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio
    import irq_hub_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic [N_OUT-1:0][2:0][31:0] msk,
    input  logic [2:0][31:0]            pend,
    output logic [N_OUT-1:0][2:0][31:0] act,
    output logic [N_OUT-1:0][31:0]      prio,
    output logic [N_OUT-1:0]            irq
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        pick_t pk_tm, pk_hw, pk_wt;

        always_comb begin
            for (int t = 0; t < 3; t++) act[o][t] = pend[t] & msk[o][t];
            pk_tm = pick_lowest(act[o][FAM_TM]);
            pk_hw = pick_lowest(act[o][FAM_HW]);
            pk_wt = pick_lowest(act[o][FAM_WT]);

            prio[o]        = '0;
            prio[o][0]     = pk_tm.hit;
            prio[o][1]     = pk_hw.hit;
            prio[o][2]     = pk_wt.hit;
            prio[o][12:8]  = pk_tm.idx;
            prio[o][20:16] = pk_hw.idx;
            prio[o][28:24] = pk_wt.idx;
            irq[o]         = pk_tm.hit | pk_hw.hit | pk_wt.hit;
        end
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int N_HW  = 8,
    parameter int N_WT  = 4,
    parameter int N_TM  = 6,
    parameter int N_OUT = 3,
    localparam int HW_W = (N_HW > 0) ? N_HW : 1,
    localparam int TM_W = (N_TM > 0) ? N_TM : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [11:0]      req_addr,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    input  logic [HW_W-1:0]  hw_irq,
    input  logic [TM_W-1:0]  tmr_irq,
    output logic [N_OUT-1:0] irq_out
);

    typedef struct packed {
        logic        vld;
        logic [31:0] data;
    } rsp_t;

    dec_t                        dec;
    logic [31:0]                 wti_rdata;
    logic [31:0]                 wti_pend;
    logic [2:0][31:0]            pend;
    logic [N_OUT-1:0][2:0][31:0] msk;
    logic [N_OUT-1:0][2:0][31:0] act;
    logic [N_OUT-1:0][31:0]      prio;
    rsp_t                        rsp_d, rsp_q;

    assign req_ready = 1'b1;

    // level sources padded to 32 lanes
    for (genvar g = 0; g < 32; g++) begin : g_lvl
        if (g < N_HW) begin : g_hw
            assign pend[FAM_HW][g] = hw_irq[g];
        end else begin : g_hw0
            assign pend[FAM_HW][g] = 1'b0;
        end
        if (g < N_TM) begin : g_tm
            assign pend[FAM_TM][g] = tmr_irq[g];
        end else begin : g_tm0
            assign pend[FAM_TM][g] = 1'b0;
        end
    end
    assign pend[FAM_WT] = wti_pend;

    irq_hub_decode #(.N_OUT(N_OUT), .N_WT(N_WT)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .dec       (dec)
    );

    irq_hub_wti #(.N_WT(N_WT)) u_wti (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (dec),
        .wdata (req_wdata),
        .rdata (wti_rdata),
        .pend  (wti_pend)
    );

    irq_hub_masks #(.N_OUT(N_OUT), .N_TM(N_TM), .N_HW(N_HW), .N_WT(N_WT)) u_msk (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (dec),
        .wdata (req_wdata),
        .msk   (msk)
    );

    irq_hub_prio #(.N_OUT(N_OUT)) u_prio (
        .msk  (msk),
        .pend (pend),
        .act  (act),
        .prio (prio),
        .irq  (irq_out)
    );

    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = req_valid;
        if (dec.wti_rd) rsp_d.data = wti_rdata;
        for (int o = 0; o < N_OUT; o++) begin
            if (dec.out_ok && 32'(dec.idx) == o) begin
                for (int t = 0; t < 3; t++) begin
                    if (dec.msk_rd[t]) rsp_d.data = msk[o][t];
                    if (dec.act_rd[t]) rsp_d.data = act[o][t];
                end
                if (dec.prio_rd) rsp_d.data = prio[o];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_rdata = rsp_q.data;

endmodule

// File: rtl/irq_hub_checks.sv
module irq_hub_checks #(
    parameter int N_WT  = 4,
    parameter int N_OUT = 3,
    parameter int HW_W  = 8,
    parameter int TM_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [11:0]      req_addr,
    input logic             rsp_valid,
    input logic [31:0]      rsp_rdata,
    input logic [HW_W-1:0]  hw_irq,
    input logic [TM_W-1:0]  tmr_irq,
    input logic [N_OUT-1:0] irq_out,
    input logic [31:0]      wti_pend
);

    logic       swrd_q;
    logic [4:0] swidx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swrd_q  <= 1'b0;
            swidx_q <= '0;
        end else begin
            swrd_q  <= req_valid && !req_write && req_addr[11:7] == 5'd0 &&
                       req_addr[1:0] == 2'b00 && 32'(req_addr[6:2]) < N_WT;
            swidx_q <= req_addr[6:2];
        end
    end

    assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_write_rsp_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'd0));

    assert_reserved_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[11]) |=> (rsp_rdata == 32'd0));

    assert_irq_needs_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> (hw_irq != '0 || tmr_irq != '0 || wti_pend != '0));

    assert_swreq_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        swrd_q |-> !wti_pend[swidx_q]);

endmodule

bind irq_hub irq_hub_checks #(
    .N_WT  (N_WT),
    .N_OUT (N_OUT),
    .HW_W  (HW_W),
    .TM_W  (TM_W)
) u_irq_hub_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .hw_irq    (hw_irq),
    .tmr_irq   (tmr_irq),
    .irq_out   (irq_out),
    .wti_pend  (wti_pend)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;

    localparam time CLK_PERIOD = 10ns;
    localparam int  N_HW  = 8;
    localparam int  N_WT  = 4;
    localparam int  N_TM  = 6;
    localparam int  N_OUT = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [11:0]      req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic             rsp_valid;
    logic [31:0]      rsp_rdata;
    logic [N_HW-1:0]  hw_irq = '0;
    logic [N_TM-1:0]  tmr_irq = '0;
    logic [N_OUT-1:0] irq_out;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_hub #(.N_HW(N_HW), .N_WT(N_WT), .N_TM(N_TM), .N_OUT(N_OUT)) i_irq_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .hw_irq    (hw_irq),
        .tmr_irq   (tmr_irq),
        .irq_out   (irq_out)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops expected response data in order
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // driver: one request, expected data pushed before the accepting edge
    task automatic xfer(bit wr, int fn, int idx, logic [31:0] wd, logic [31:0] exp, string tag,
                        logic [1:0] low = 2'b00);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {5'(fn), 5'(idx), low};
        req_wdata = wd;
        exp_q.push_back(wr ? 32'd0 : exp);
        tag_q.push_back(tag);
        check("R2 ready", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        check("R2 response next cycle", {31'd0, rsp_valid}, 32'd1);
    endtask

    task automatic chk_irq(string tag, logic [N_OUT-1:0] exp);
        #1;
        check(tag, 32'(irq_out), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset irq_out", 32'(irq_out), 32'd0);
        check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle no response", {31'd0, rsp_valid}, 32'd0);

        // R1: state after reset
        xfer(0, 4, 0, 0, 32'h0, "R1 tm mask reset");
        xfer(0, 0, 3, 0, 32'h0, "R1 swreq reset");

        // R3: store, read back with clear
        xfer(1, 0, 2, 32'h55, 0, "R3 write");
        xfer(0, 0, 2, 0, 32'h55, "R3 read value");
        xfer(0, 0, 2, 0, 32'h0, "R3 read cleared");

        // R4: full mask write limited to source count
        xfer(1, 4, 0, 32'hFFFF_FFFF, 0, "R4 tm write");
        xfer(0, 4, 0, 0, 32'h3F, "R4 tm read");
        xfer(1, 12, 2, 32'h0F0F, 0, "R4 wt write");
        xfer(0, 12, 2, 0, 32'h0F, "R4 wt read");
        xfer(1, 12, 2, 0, 0, "R4 wt zero");

        // R5: set and clear aliases on hw mask of output 1
        xfer(1, 8, 1, 0, 0, "R5 hw zero");
        xfer(1, 9, 1, 32'h05, 0, "R5 set a");
        xfer(1, 9, 1, 32'h10, 0, "R5 set b");
        xfer(0, 8, 1, 0, 32'h15, "R5 after set");
        xfer(1, 10, 1, 32'h04, 0, "R5 clear");
        xfer(0, 8, 1, 0, 32'h11, "R5 after clear");
        chk_irq("R7 no source", 3'b000);

        // R6/R7/R8: hardware activity
        @(negedge clk);
        hw_irq = 8'h13;
        chk_irq("R7 hw on out1", 3'b010);
        xfer(0, 10, 1, 0, 32'h11, "R6 hw active");
        xfer(0, 15, 1, 0, 32'h0000_0002, "R8 hw idx0");
        @(negedge clk);
        hw_irq = 8'h12;
        xfer(0, 15, 1, 0, 32'h0004_0002, "R8 hw idx4");

        // timer activity on out0
        @(negedge clk);
        tmr_irq = 6'h28;
        chk_irq("R7 tm on out0", 3'b011);
        xfer(0, 6, 0, 0, 32'h28, "R6 tm active");
        xfer(0, 15, 0, 0, 32'h0000_0301, "R8 tm idx3");

        // software activity on out2
        xfer(1, 13, 2, 32'h02, 0, "R5 wt set");
        xfer(1, 0, 1, 32'h7, 0, "R3 write 1");
        chk_irq("R7 wt on out2", 3'b111);
        xfer(0, 15, 2, 0, 32'h0100_0004, "R8 wt idx1");
        xfer(0, 14, 2, 0, 32'h02, "R6 wt active");
        xfer(0, 0, 1, 0, 32'h7, "R3 ack read");
        chk_irq("R3 ack drops out2", 3'b011);

        // R9: reserved and out-of-range accesses
        xfer(1, 16, 0, 32'hFFFF_FFFF, 0, "R9 write reserved");
        xfer(0, 16, 0, 0, 32'h0, "R9 read reserved");
        xfer(1, 4, 5, 32'h3F, 0, "R9 write idx out");
        xfer(0, 4, 5, 0, 32'h0, "R9 read idx out");
        xfer(1, 0, 6, 32'h9, 0, "R9 swreq idx out");
        xfer(0, 0, 6, 0, 32'h0, "R9 swreq read out");
        xfer(0, 9, 1, 0, 32'h0, "R9 read set alias");
        xfer(0, 1, 0, 0, 32'h0, "R9 read func1");
        xfer(1, 12, 0, 32'hF, 0, "R9 misaligned write", 2'b01);
        xfer(0, 12, 0, 0, 32'h0, "R9 misaligned no effect");
        xfer(1, 4, 1, 32'h3F, 0, "R9 func7 setup");
        xfer(1, 7, 1, 32'h3F, 0, "R9 func7 write");
        xfer(0, 7, 1, 0, 32'h0, "R9 func7 read");
        xfer(0, 4, 2, 0, 32'h0, "R9 out2 tm untouched");

        // R10: level sources not latched
        @(negedge clk);
        hw_irq  = '0;
        tmr_irq = '0;
        chk_irq("R10 levels removed", 3'b000);
        xfer(0, 10, 1, 0, 32'h0, "R10 hw active gone");

        repeat (2) @(negedge clk);
        check("R2 queue drained", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

endmodule